// File: doc/BRIEF.md
# Butterfly Weight Accumulator Range Detector

This block takes a difference vector, for example the bitwise XOR of a stored codeword and a freshly encoded incoming word, and reports which of four ranges its number of set bits falls in: none, one, two, or three and more. A match/no-match decision in an error-tolerant compare only needs that range, so the block never forms the exact population count.

Bits are first paired into half adders. Each half adder's sum line carries weight 1 and its carry line carries weight 2. A tree of merge nodes then combines neighbouring groups. At each node the sum lines are paired only with sum lines and the carry lines only with carry lines, so every line still has an exact weight. Any line that would carry weight 4 or more is folded into one saturation bit by OR gates and goes no further up the adder chain. A small decoder turns the root's three lines (weight 1, weight 2, saturation) into four one-hot range flags. The block is purely combinational, with no clock and no state.

Top module: `bwa_range_det`

## Requirements
- R1: `rng_zero_o` is 1 exactly when no bit of `diff_i` is set.
- R2: `rng_one_o` is 1 exactly when one bit of `diff_i` is set.
- R3: `rng_two_o` is 1 exactly when two bits of `diff_i` are set, whether they share a first-level pair or not.
- R4: `rng_many_o` is 1 exactly when three or more bits of `diff_i` are set, up to and including all bits set.
- R5: For every input value, exactly one of the four range flags is 1. The flags ordered as {many, two, one, zero} form a one-hot 4-bit code.
- R6: The flags depend only on how many bits are set, not on their positions, and follow the current value of `diff_i` with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| diff_i | input | N_BITS | Difference vector whose set-bit count is classified |
| rng_zero_o | output | 1 | No bit set |
| rng_one_o | output | 1 | Exactly one bit set |
| rng_two_o | output | 1 | Exactly two bits set |
| rng_many_o | output | 1 | Three or more bits set |

## Verification
The bench builds the block with N_BITS = 8, which gives four first-level pairs and two merge levels. At this width all 256 input vectors can be enumerated, so every combination of weight-1 sums, weight-2 carries and saturation lines at every node is reached and compared with a popcount computed in the bench. The directed table first covers the critical cases: two bits inside one pair versus two bits in different pairs, three bits spread so that no weight-4 carry appears, and all bits set.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  // Weighted lines of one subtree: sat = some weight-4 or higher line set
  typedef struct packed {
    logic sat;
    logic w2;
    logic w1;
  } bwa_wt_t;
endpackage

// File: rtl/bwa_ha.sv
module bwa_ha (
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic cry_o
);
  assign sum_o = a_i ^ b_i;
  assign cry_o = a_i & b_i;
endmodule

// File: rtl/bwa_leaf.sv
module bwa_leaf
  import bwa_pkg::*;
(
  input  logic [1:0] pair_i,
  output bwa_wt_t    wt_o
);
  logic s, c;

  bwa_ha u_ha (.a_i(pair_i[0]), .b_i(pair_i[1]), .sum_o(s), .cry_o(c));

  assign wt_o.w1  = s;
  assign wt_o.w2  = c;
  assign wt_o.sat = 1'b0;
endmodule

// File: rtl/bwa_merge.sv
module bwa_merge
  import bwa_pkg::*;
(
  input  bwa_wt_t lo_i,
  input  bwa_wt_t hi_i,
  output bwa_wt_t wt_o
);
  logic s1, k2;      // weight 1 sum, weight 2 carry from the sum lines
  logic m2, q4a;     // weight 2 sum, weight 4 carry from the carry lines
  logic c2, q4b;     // final weight 2 line, second weight 4 carry

  // sums pair with sums
  bwa_ha u_ha_sum (.a_i(lo_i.w1), .b_i(hi_i.w1), .sum_o(s1), .cry_o(k2));
  // carries pair with carries
  bwa_ha u_ha_cry (.a_i(lo_i.w2), .b_i(hi_i.w2), .sum_o(m2), .cry_o(q4a));
  // both weight 2: the fresh carry joins the carry chain
  bwa_ha u_ha_w2  (.a_i(m2),      .b_i(k2),      .sum_o(c2), .cry_o(q4b));

  assign wt_o.w1  = s1;
  assign wt_o.w2  = c2;
  // weight >= 4 needs no exact value: OR tree
  assign wt_o.sat = lo_i.sat | hi_i.sat | q4a | q4b;
endmodule

// File: rtl/bwa_decode.sv
module bwa_decode
  import bwa_pkg::*;
(
  input  bwa_wt_t wt_i,
  output logic    zero_o,
  output logic    one_o,
  output logic    two_o,
  output logic    many_o
);
  assign zero_o = ~wt_i.sat & ~wt_i.w2 & ~wt_i.w1;
  assign one_o  = ~wt_i.sat & ~wt_i.w2 &  wt_i.w1;
  assign two_o  = ~wt_i.sat &  wt_i.w2 & ~wt_i.w1;
  assign many_o =  wt_i.sat | (wt_i.w2 & wt_i.w1);
endmodule

// File: rtl/bwa_range_det.sv
module bwa_range_det
  import bwa_pkg::*;
#(
  parameter int N_BITS = 8   // power of two, at least 2
) (
  input  logic [N_BITS-1:0] diff_i,
  output logic              rng_zero_o,
  output logic              rng_one_o,
  output logic              rng_two_o,
  output logic              rng_many_o
);
  localparam int LEAVES = N_BITS / 2;
  localparam int NODES  = 2 * LEAVES - 1;
  localparam int FIRST_LEAF = LEAVES - 1;

  // heap order: node 0 is the root, children of i are 2i+1 and 2i+2
  bwa_wt_t node [NODES];

  for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
    bwa_leaf u_leaf (
      .pair_i(diff_i[2*g+1:2*g]),
      .wt_o  (node[FIRST_LEAF+g])
    );
  end

  for (genvar g = 0; g < FIRST_LEAF; g++) begin : g_merge
    bwa_merge u_merge (
      .lo_i(node[2*g+1]),
      .hi_i(node[2*g+2]),
      .wt_o(node[g])
    );
  end

  bwa_decode u_dec (
    .wt_i  (node[0]),
    .zero_o(rng_zero_o),
    .one_o (rng_one_o),
    .two_o (rng_two_o),
    .many_o(rng_many_o)
  );
endmodule

// File: rtl/bwa_range_det_chk.sv
module bwa_range_det_chk #(
  parameter int N_BITS = 8
) (
  input logic [N_BITS-1:0] diff_i,
  input logic              rng_zero_o,
  input logic              rng_one_o,
  input logic              rng_two_o,
  input logic              rng_many_o
);
  int unsigned ones;
  assign ones = $countones(diff_i);

  always_comb begin
    // R1
    zero_flag_chk: assert (rng_zero_o == (ones == 0))
      else $error("zero flag disagrees with input");
    // R2
    one_flag_chk: assert (rng_one_o == (ones == 1))
      else $error("one flag disagrees with input");
    // R3
    two_flag_chk: assert (rng_two_o == (ones == 2))
      else $error("two flag disagrees with input");
    // R4
    many_flag_chk: assert (rng_many_o == (ones >= 3))
      else $error("many flag disagrees with input");
    // R5
    onehot_flags_chk: assert ($onehot({rng_many_o, rng_two_o, rng_one_o, rng_zero_o}))
      else $error("range flags not one-hot");
  end
endmodule

bind bwa_range_det bwa_range_det_chk #(.N_BITS(N_BITS)) u_chk (
  .diff_i    (diff_i),
  .rng_zero_o(rng_zero_o),
  .rng_one_o (rng_one_o),
  .rng_two_o (rng_two_o),
  .rng_many_o(rng_many_o)
);

// File: tb/bwa_range_det_bench.sv
`timescale 1ns/1ps
module bwa_range_det_bench;
  localparam int N_BITS = 8;
  localparam int NTBL   = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [N_BITS-1:0] diff;
  logic z, o, t, m;
  int n_chk = 0;
  int n_bad = 0;

  bwa_range_det #(.N_BITS(N_BITS)) u_bwa_range_det (
    .diff_i(diff), .rng_zero_o(z), .rng_one_o(o), .rng_two_o(t), .rng_many_o(m)
  );

  // {vector, expected {many,two,one,zero}}
  localparam logic [11:0] VEC_TBL [NTBL] = '{
    {8'h00, 4'b0001},  // R1 all clear
    {8'h01, 4'b0010},  // R2
    {8'h80, 4'b0010},  // R2
    {8'h03, 4'b0100},  // R3 same pair
    {8'h81, 4'b0100},  // R3 far apart
    {8'h11, 4'b0100},  // R3 across groups
    {8'h90, 4'b0100},  // R3
    {8'h07, 4'b1000},  // R4
    {8'hA8, 4'b1000},  // R4 no weight-4 carry
    {8'h0F, 4'b1000},  // R4
    {8'h55, 4'b1000},  // R4
    {8'hFF, 4'b1000}   // R4 saturated
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s diff=%h actual=%b expected=%b", req, diff, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_flags(input logic [N_BITS-1:0] v);
    int c = $countones(v);
    return (c == 0) ? 4'b0001 : (c == 1) ? 4'b0010 : (c == 2) ? 4'b0100 : 4'b1000;
  endfunction

  function automatic string req_of(input logic [N_BITS-1:0] v);
    int c = $countones(v);
    return (c == 0) ? "R1" : (c == 1) ? "R2" : (c == 2) ? "R3" : "R4";
  endfunction

  initial begin
    diff = '0;
    @(negedge clk);
    #1 check("R1", {m, t, o, z}, 4'b0001);

    for (int i = 0; i < NTBL; i++) begin
      @(negedge clk);
      diff = VEC_TBL[i][11:4];
      #1 check(req_of(diff), {m, t, o, z}, VEC_TBL[i][3:0]);
    end

    // R5 R6: exhaustive, flags from count only, one-hot
    for (int v = 0; v < (1 << N_BITS); v++) begin
      @(negedge clk);
      diff = N_BITS'(v);
      #1 check(req_of(diff), {m, t, o, z}, ref_flags(diff));
      check("R5", 4'($countones({m, t, o, z})), 4'd1);
    end

    // R6: output follows input with no clock edge in between
    @(posedge clk);
    #0.5 diff = 8'h03;
    #0.5 check("R6", {m, t, o, z}, 4'b0100);
    diff = 8'h00;
    #0.5 check("R6", {m, t, o, z}, 4'b0001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule